// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Detector

This block sits beside the array of a 32K x 8 parallel memory that has a nonvolatile shadow copy. It watches the chip-enable-delimited read cycles on the memory port. When it sees one exact six-step address pattern, it starts either a store or a recall. A store copies the volatile array into the shadow copy. A recall reloads the volatile array from the shadow copy. Every control input is sampled on the system clock. The address of a bus cycle is taken when chip enable falls. The cycle is judged as a read or a write when chip enable rises.

The two patterns share the same five opening addresses, and the sixth address chooses the operation. When a pattern completes, the block raises a lockout flag that disables the memory for a fixed number of clock cycles. It also pulses one start strobe. A recall gets two strobes in turn: first a clear strobe, then a transfer strobe. A store is refused while the supply-low flag is raised, but a recall is not. The arrays themselves belong to the surrounding logic.

Top module: `nv_seq_guard`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `busy_o`, `store_go_o`, `clr_go_o` and `xfer_go_o` are 0. Reset also clears any partly matched pattern.
- R2: Six consecutive read cycles at hex addresses 0E38, 31C7, 03E0, 3C1F, 303F, 0FC0 start a store. `store_go_o` is high for exactly one cycle, starting one clock after the clock that samples the final rise of `ce_n_i`.
- R3: The same first five addresses followed by 0C63 start a recall. `clr_go_o` pulses for one cycle at the start of the lockout, and `xfer_go_o` pulses on the following cycle. Recalls may be repeated back to back.
- R4: A cycle's address is the value of `addr_i` at the clock that first sees `ce_n_i` low. Changes to `addr_i` while `ce_n_i` stays low have no effect.
- R5: A cycle is a write if `we_n_i` is seen low on any clock while `ce_n_i` is low. A write cycle clears any partial match.
- R6: `oe_n_i` has no effect on matching.
- R7: A read that does not continue the pattern clears the partial match. The exception is a read of 0E38, which counts as step one of a new pattern.
- R8: `busy_o` rises together with the start strobe and stays high for exactly `STORE_CYC` cycles after a store, or exactly `RECALL_CYC` cycles after a recall. `RECALL_CYC` must be at least 2.
- R9: While `busy_o` is high, bus cycles are ignored and no progress is kept. A cycle whose chip enable fell during the lockout is ignored even if it ends after the lockout.
- R10: If `vlow_i` is high when a store pattern completes, no store starts, `busy_o` stays low and the partial match is cleared. A recall pattern still starts a recall while `vlow_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 15 | Memory port address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low (not used for matching) |
| we_n_i | input | 1 | Write enable, active low |
| vlow_i | input | 1 | Supply-low flag |
| store_go_o | output | 1 | One-cycle store start strobe |
| clr_go_o | output | 1 | One-cycle recall clear strobe |
| xfer_go_o | output | 1 | One-cycle recall transfer strobe, one cycle after the clear strobe |
| busy_o | output | 1 | Lockout active; the memory is disabled |

## Verification
The hardest situation to reach is a bus cycle that straddles the end of a lockout. Its chip enable falls while `busy_o` is high and rises after the lockout has ended. If that cycle were counted as the first step, the rest of a pattern would wrongly complete. The stimulus starts a recall and drops chip enable at 0E38 during the lockout. It holds chip enable low until `busy_o` clears, then sends the remaining five store addresses and expects no store. Random runs mix pattern-continuing addresses, stray 0E38 restarts, late write strobes, address changes while chip enable is low, and supply-low flags. They are checked against a reference step model kept in the bench.

// File: rtl/nvsg_pkg.sv
package nvsg_pkg;

    localparam int ADDR_W   = 15;
    localparam int PREFIX_N = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [2:0]        step_t;

    localparam step_t STEP_FULL = 3'(PREFIX_N);

    localparam addr_t STORE_TAIL  = 15'h0FC0;
    localparam addr_t RECALL_TAIL = 15'h0C63;

    // Shared opening of both unlock patterns, in the order it must be seen.
    function automatic addr_t prefix_addr(input int unsigned idx);
        case (idx)
            0:       prefix_addr = 15'h0E38;
            1:       prefix_addr = 15'h31C7;
            2:       prefix_addr = 15'h03E0;
            3:       prefix_addr = 15'h3C1F;
            4:       prefix_addr = 15'h303F;
            default: prefix_addr = '0;
        endcase
    endfunction

    // One finished chip-enable cycle, as seen by the matcher.
    typedef struct packed {
        logic  valid;
        logic  is_write;
        addr_t addr;
    } bus_cyc_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } op_e;

endpackage

// File: rtl/nvsg_capture.sv
module nvsg_capture
    import nvsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  addr_t    addr_i,
    input  logic     ce_n_i,
    input  logic     we_n_i,
    input  logic     blocked_i,
    output bus_cyc_t cyc_o
);

    logic  ce_q;
    logic  open_q;
    logic  wr_q;
    addr_t addr_q;
    logic  ce_fall;
    logic  ce_rise;

    assign ce_fall = ce_q & ~ce_n_i;
    assign ce_rise = ~ce_q & ce_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q   <= 1'b1;
            open_q <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            cyc_o  <= '0;
        end else begin
            ce_q        <= ce_n_i;
            cyc_o.valid <= 1'b0;
            if (blocked_i) begin
                // Any cycle touched by the lockout is dropped.
                open_q <= 1'b0;
            end else if (ce_fall) begin
                open_q <= 1'b1;
                addr_q <= addr_i;
                wr_q   <= ~we_n_i;
            end else if (open_q && ce_rise) begin
                open_q         <= 1'b0;
                cyc_o.valid    <= 1'b1;
                cyc_o.is_write <= wr_q;
                cyc_o.addr     <= addr_q;
            end else if (open_q && !ce_n_i) begin
                wr_q <= wr_q | ~we_n_i;
            end
        end
    end

endmodule

// File: rtl/nvsg_match.sv
module nvsg_match
    import nvsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cyc_t cyc_i,
    input  logic     blocked_i,
    input  logic     vlow_i,
    output op_e      req_o
);

    step_t                step_q;
    step_t                step_d;
    logic [PREFIX_N-1:0]  pfx_hit;
    logic                 expect_hit;
    logic                 at_full;

    for (genvar g = 0; g < PREFIX_N; g++) begin : g_pfx
        assign pfx_hit[g] = (cyc_i.addr == prefix_addr(g));
    end

    always_comb begin
        expect_hit = 1'b0;
        for (int i = 0; i < PREFIX_N; i++) begin
            if (step_q == step_t'(i)) expect_hit = pfx_hit[i];
        end
    end

    assign at_full = (step_q == STEP_FULL);

    always_comb begin
        req_o  = OP_NONE;
        step_d = step_q;
        if (blocked_i) begin
            step_d = '0;
        end else if (cyc_i.valid) begin
            if (cyc_i.is_write) begin
                step_d = '0;
            end else if (at_full && cyc_i.addr == STORE_TAIL) begin
                step_d = '0;
                req_o  = vlow_i ? OP_NONE : OP_STORE;
            end else if (at_full && cyc_i.addr == RECALL_TAIL) begin
                step_d = '0;
                req_o  = OP_RECALL;
            end else if (expect_hit) begin
                step_d = step_q + 3'd1;
            end else if (pfx_hit[0]) begin
                step_d = 3'd1;
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

endmodule

// File: rtl/nvsg_lockout.sv
module nvsg_lockout
    import nvsg_pkg::*;
#(
    parameter int STORE_CYC  = 2000,
    parameter int RECALL_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  op_e  req_i,
    output logic busy_o,
    output logic store_go_o,
    output logic clr_go_o,
    output logic xfer_go_o
);

    localparam int LONGEST = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            busy_o     <= 1'b0;
            store_go_o <= 1'b0;
            clr_go_o   <= 1'b0;
            xfer_go_o  <= 1'b0;
        end else begin
            store_go_o <= 1'b0;
            clr_go_o   <= 1'b0;
            xfer_go_o  <= clr_go_o;
            if (!busy_o && req_i == OP_STORE) begin
                busy_o     <= 1'b1;
                cnt_q      <= CNT_W'(STORE_CYC - 1);
                store_go_o <= 1'b1;
            end else if (!busy_o && req_i == OP_RECALL) begin
                busy_o   <= 1'b1;
                cnt_q    <= CNT_W'(RECALL_CYC - 1);
                clr_go_o <= 1'b1;
            end else if (busy_o) begin
                if (cnt_q == '0) busy_o <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/nv_seq_guard.sv
module nv_seq_guard
    import nvsg_pkg::*;
#(
    parameter int STORE_CYC  = 2000,
    parameter int RECALL_CYC = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] addr_i,
    input  logic        ce_n_i,
    input  logic        oe_n_i,
    input  logic        we_n_i,
    input  logic        vlow_i,
    output logic        store_go_o,
    output logic        clr_go_o,
    output logic        xfer_go_o,
    output logic        busy_o
);

    bus_cyc_t cyc;
    op_e      req;
    logic     oe_unused;

    // Output enable plays no part in recognising a pattern step.
    assign oe_unused = oe_n_i;

    nvsg_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .ce_n_i    (ce_n_i),
        .we_n_i    (we_n_i),
        .blocked_i (busy_o),
        .cyc_o     (cyc)
    );

    nvsg_match u_match (
        .clk       (clk),
        .rst       (rst),
        .cyc_i     (cyc),
        .blocked_i (busy_o),
        .vlow_i    (vlow_i),
        .req_o     (req)
    );

    nvsg_lockout #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_lockout (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .busy_o     (busy_o),
        .store_go_o (store_go_o),
        .clr_go_o   (clr_go_o),
        .xfer_go_o  (xfer_go_o)
    );

endmodule

// File: rtl/nvsg_checker.sv
module nvsg_checker #(
    parameter int STORE_CYC  = 2000,
    parameter int RECALL_CYC = 200
) (
    input logic clk,
    input logic rst,
    input logic vlow_i,
    input logic store_go_o,
    input logic clr_go_o,
    input logic xfer_go_o,
    input logic busy_o
);

    int run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_q <= 0;
        else                run_q <= run_q + 1;
    end

    // R1: reset leaves every output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy_o && !store_go_o && !clr_go_o && !xfer_go_o));

    // R2: the store strobe lasts one cycle
    a_r2_store_single: assert property (@(posedge clk) disable iff (rst)
        store_go_o |=> !store_go_o);

    // R3: the transfer strobe follows the clear strobe
    a_r3_clear_then_xfer: assert property (@(posedge clk) disable iff (rst)
        clr_go_o |=> (xfer_go_o && !clr_go_o));

    // R3: the transfer strobe is never seen without a preceding clear strobe
    a_r3_xfer_has_clear: assert property (@(posedge clk) disable iff (rst)
        xfer_go_o |-> $past(clr_go_o));

    // R8: the lockout opens with exactly one start strobe
    a_r8_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (store_go_o || clr_go_o));

    // R8: at most one strobe at a time
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_go_o, clr_go_o, xfer_go_o}));

    // R8: the lockout lasts one of the two set durations
    a_r8_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == STORE_CYC || run_q == RECALL_CYC));

    // R9: no new operation begins during a lockout
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (!store_go_o && !clr_go_o));

    // R10: no store is started from a supply-low cycle
    a_r10_lowv_store: assert property (@(posedge clk) disable iff (rst)
        store_go_o |-> !$past(vlow_i));

endmodule

bind nv_seq_guard nvsg_checker #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vlow_i     (vlow_i),
    .store_go_o (store_go_o),
    .clr_go_o   (clr_go_o),
    .xfer_go_o  (xfer_go_o),
    .busy_o     (busy_o)
);

// File: tb/nv_seq_guard_test.sv
module nv_seq_guard_test;

    localparam int SC = 40;
    localparam int RC = 16;
    localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                            K3 = 15'h3C1F, K4 = 15'h303F;
    localparam logic [14:0] TS = 15'h0FC0, TR = 15'h0C63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [14:0] addr = '0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vlow = 1'b0;
    logic store_go, clr_go, xfer_go, busy;

    int nvec = 0;
    int nbad = 0;
    int ref_step = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nv_seq_guard #(.STORE_CYC(SC), .RECALL_CYC(RC)) uut (
        .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .we_n_i(we_n), .vlow_i(vlow), .store_go_o(store_go), .clr_go_o(clr_go),
        .xfer_go_o(xfer_go), .busy_o(busy)
    );

    function automatic logic [14:0] key(input int i);
        case (i)
            0: key = K0; 1: key = K1; 2: key = K2; 3: key = K3;
            default: key = K4;
        endcase
    endfunction

    // Reference step model: returns 0 none, 1 store, 2 recall.
    function automatic int ref_apply(input logic [14:0] a, input bit wr, input bit lv);
        int op = 0;
        if (wr) ref_step = 0;
        else if (ref_step == 5 && a == TS) begin ref_step = 0; op = lv ? 0 : 1; end
        else if (ref_step == 5 && a == TR) begin ref_step = 0; op = 2; end
        else if (ref_step < 5 && a == key(ref_step)) ref_step++;
        else ref_step = (a == K0) ? 1 : 0;
        return op;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One chip-enable cycle: len low clocks, write strobe on low clock wr_at.
    task automatic rd(input logic [14:0] a, input int wr_at, input bit oe,
                      input int len, input bit wob);
        @(negedge clk);
        ce_n = 1'b0; addr = a; oe_n = oe; we_n = !(wr_at == 0);
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            we_n = !(wr_at == k);
            if (wob) addr = ~a;
        end
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; addr = 15'h5555;
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_op(input int op, input string tag);
        int n;
        if (op == 0) begin
            check({tag, " idle busy"}, busy, 0);
            check({tag, " no store"}, store_go, 0);
            check({tag, " no clear"}, clr_go, 0);
            return;
        end
        check({tag, " busy up"}, busy, 1);
        check({tag, " store strobe"}, store_go, op == 1);
        check({tag, " clear strobe"}, clr_go, op == 2);
        n = 1;
        @(negedge clk);
        check({tag, " store strobe ends"}, store_go, 0);
        check({tag, " transfer strobe"}, xfer_go, op == 2);
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check({tag, " R8 busy length"}, n, (op == 1) ? SC : RC);
    endtask

    task automatic step(input logic [14:0] a, input int wr_at, input bit oe,
                        input int len, input bit lv, input bit wob, input string tag);
        int op;
        vlow = lv;
        op = ref_apply(a, (wr_at >= 0) && (wr_at < len), lv);
        rd(a, wr_at, oe, len, wob);
        expect_op(op, tag);
    endtask

    task automatic prefix(input string tag);
        for (int i = 0; i < 5; i++) step(key(i), -1, 1'b0, 1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 strobes in reset", store_go | clr_go | xfer_go, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);

        // R1: partial match lost on reset
        prefix("R1 prefix");
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; ref_step = 0;
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R1 tail after reset");

        // R2 and R3 basic
        prefix("R2"); step(TS, -1, 1'b0, 2, 1'b0, 1'b0, "R2 store");
        prefix("R3"); step(TR, -1, 1'b0, 1, 1'b0, 1'b0, "R3 recall");
        prefix("R3 again"); step(TR, -1, 1'b1, 3, 1'b0, 1'b0, "R3 repeat recall");

        // R4 address wobble while low, R6 output enable high
        for (int i = 0; i < 5; i++) step(key(i), -1, 1'b1, 3, 1'b0, 1'b1, "R4 R6 prefix");
        step(TS, -1, 1'b1, 3, 1'b0, 1'b1, "R4 R6 store");

        // R5 late write strobe in the middle
        step(K0, -1, 1'b0, 1, 1'b0, 1'b0, "R5");
        step(K1, -1, 1'b0, 1, 1'b0, 1'b0, "R5");
        step(K2, 2, 1'b0, 3, 1'b0, 1'b0, "R5 write step");
        step(K3, -1, 1'b0, 1, 1'b0, 1'b0, "R5");
        step(K4, -1, 1'b0, 1, 1'b0, 1'b0, "R5");
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R5 no store");

        // R7 restart on 0E38, and plain mismatch
        step(K0, -1, 1'b0, 1, 1'b0, 1'b0, "R7");
        step(K1, -1, 1'b0, 1, 1'b0, 1'b0, "R7");
        prefix("R7 restart");
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R7 store after restart");
        step(K0, -1, 1'b0, 1, 1'b0, 1'b0, "R7");
        step(K1, -1, 1'b0, 1, 1'b0, 1'b0, "R7");
        step(15'h1234, -1, 1'b0, 1, 1'b0, 1'b0, "R7 mismatch");
        for (int i = 2; i < 5; i++) step(key(i), -1, 1'b0, 1, 1'b0, 1'b0, "R7");
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R7 no store");

        // R10 supply low
        prefix("R10"); step(TS, -1, 1'b0, 1, 1'b1, 1'b0, "R10 store blocked");
        prefix("R10"); step(TR, -1, 1'b0, 1, 1'b1, 1'b0, "R10 recall allowed");
        vlow = 1'b0;

        // R9 cycles during a store lockout
        prefix("R9");
        vlow = 1'b0;
        rd(TS, -1, 1'b0, 1, 1'b0);
        check("R9 store strobe", store_go, 1);
        for (int i = 0; i < 5; i++) rd(key(i), -1, 1'b0, 1, 1'b0);
        rd(TS, -1, 1'b0, 1, 1'b0);
        check("R9 no store in lockout", store_go, 0);
        check("R9 still busy", busy, 1);
        while (busy) @(negedge clk);
        ref_step = 0;
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R9 no progress kept");

        // R9 cycle straddling the end of a recall lockout
        prefix("R9 straddle");
        rd(TR, -1, 1'b0, 1, 1'b0);
        check("R9 recall strobe", clr_go, 1);
        @(negedge clk); ce_n = 1'b0; addr = K0;
        while (busy) @(negedge clk);
        @(negedge clk); @(negedge clk); ce_n = 1'b1;
        @(negedge clk); @(negedge clk);
        ref_step = 0;
        for (int i = 1; i < 5; i++) step(key(i), -1, 1'b0, 1, 1'b0, 1'b0, "R9 straddle");
        step(TS, -1, 1'b0, 1, 1'b0, 1'b0, "R9 straddle no store");

        // Random mix (R2 R3 R5 R7 R10)
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            logic [14:0] a;
            int r = $urandom_range(99);
            int len = $urandom_range(1, 3);
            int wr = ($urandom_range(99) < 8) ? $urandom_range(0, len - 1) : -1;
            bit lv = ($urandom_range(99) < 10);
            if (r < 65) a = (ref_step < 5) ? key(ref_step) : (($urandom_range(1) == 1) ? TS : TR);
            else if (r < 80) a = K0;
            else a = 15'($urandom);
            step(a, wr, $urandom_range(1) == 1, len, lv, $urandom_range(1) == 1, "R2 R3 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule